// File: doc/BRIEF.md
# Priority Backlog Counter Array

This block holds a bank of backlog counters for a few interrupt targets, with one counter for each of eight priority levels per target. Each target index has two kinds of counter. One is for a single processor and is clamped to the range 0..1. The other is for a group and holds a 16-bit count. Software and neighbouring logic reach the counters through a simple memory-mapped request port. The address names the target, the counter kind, the priority and the operation, so the access itself carries the command.

A byte store carries a delta that is added to or subtracted from the addressed counter. A halfword load returns the current count one cycle after the request. Depending on the operation code, the load may then also move the counter up or down by one. Counters never go below zero. Group counters stop at 0xFFFF instead of wrapping. Addresses that hit no counter read as zero, and stores to them are dropped.

Top module: `bklg_counter_array`

## Requirements
- R1: Address layout: the operation code is `addr[11:10]` and the priority is `addr[6:4]`. Bit 12 picks the counter kind (0 = processor, 1 = group). `addr[15:13]` is the target index, so each index spans two 4 KiB pages.
- R2: `req_write` is the access kind. 1 is a byte store whose delta is `req_wdata[7:0]` and which gives no response. 0 is a load that raises `rsp_valid` for one cycle on the next clock edge, with the 16-bit result on `rsp_rdata`.
- R3: A processor counter only holds 0 or 1. An increment store (code 00) of any delta sets it to 1, and a decrement store (code 01) of any delta clears it to 0.
- R4: An increment store on a group counter adds the full delta and saturates at 0xFFFF.
- R5: No decrement, store or load, takes a counter below zero. A decrement larger than the count leaves 0.
- R6: An increment load (code 00) or decrement load (code 01) returns the value held before the access and then steps the counter by exactly one. The same clamping rules apply.
- R7: Codes 10 and 11 are pure peeks. A load with either code returns the count and leaves it unchanged, and a store with either code changes nothing.
- R8: All counters are zero after reset. A target index of 3 or more, or any set bit in `addr[9:7]` or `addr[3:0]`, is unmapped: it reads 0 and its stores are ignored.
- R9: Every target, counter kind and priority has its own counter, and an access changes only the counter it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = delta store, 0 = load |
| req_addr | input | 16 | Offset encoding target, kind, operation and priority |
| req_wdata | input | 8 | Delta for stores |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | 16 | Load result: count before the access |

## Verification
The bench goes after the clamp on processor counters. A design that treated them like group counters would read back 7 after a store of 7, or 2 after two increments. It also drives decrements below zero with a store of 9 and a load on an empty counter; a design that wrapped would return 0xFFF7 or 0xFFFF. A group counter is pushed past its ceiling with 258 stores of 255, which exposes a wrapping adder. Peek-coded stores, stray offset bits and an out-of-range index are each followed by a read of the counter they could have touched. A design that aliased them would show a changed count or a nonzero unmapped read.

// File: rtl/bklg_pkg.sv
package bklg_pkg;
    localparam int NUM_PRIO = 8;
    localparam int PRIO_W   = $clog2(NUM_PRIO);
    localparam int PRIO_LSB = 4;
    localparam int OPC_W    = 2;
    localparam int OPC_LSB  = 10;

    typedef enum logic [OPC_W-1:0] {
        OPC_INC    = 2'b00,
        OPC_DEC    = 2'b01,
        OPC_PEEK_A = 2'b10,
        OPC_PEEK_B = 2'b11
    } bklg_opc_e;
endpackage

// File: rtl/bklg_decode.sv
module bklg_decode
    import bklg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_TARGETS = 3,
    localparam int IDX_W      = ADDR_W - PAGE_SHIFT - 1,
    localparam int TGT_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped,
    output logic [TGT_W-1:0]  tgt,
    output logic              is_group,
    output logic [PRIO_W-1:0] prio,
    output bklg_opc_e         opc
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_TARGETS);

    // offset bits that carry meaning; all others must be zero
    function automatic logic [PAGE_SHIFT-1:0] used_mask();
        logic [PAGE_SHIFT-1:0] m;
        m = '0;
        for (int b = 0; b < OPC_W; b++) m[OPC_LSB + b] = 1'b1;
        for (int b = 0; b < PRIO_W; b++) m[PRIO_LSB + b] = 1'b1;
        return m;
    endfunction
    localparam logic [PAGE_SHIFT-1:0] USED_MASK = used_mask();

    logic [IDX_W-1:0] idx_field;
    logic             stray;

    always_comb begin
        idx_field = addr[ADDR_W-1 -: IDX_W];
        stray     = |(addr[PAGE_SHIFT-1:0] & ~USED_MASK);
        mapped    = (idx_field < IDX_LIMIT) && !stray;
        tgt       = idx_field[TGT_W-1:0];
        is_group  = addr[PAGE_SHIFT];
        prio      = addr[PRIO_LSB +: PRIO_W];
        opc       = bklg_opc_e'(addr[OPC_LSB +: OPC_W]);
    end
endmodule

// File: rtl/bklg_step.sv
module bklg_step
    import bklg_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DELTA_W = 8
) (
    input  logic [CNT_W-1:0]   old_val,
    input  logic               is_group,
    input  logic               is_store,
    input  bklg_opc_e          opc,
    input  logic [DELTA_W-1:0] delta,
    output logic [CNT_W-1:0]   new_val,
    output logic               upd_en
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] amount;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] up_val;
    logic [CNT_W-1:0] down_val;

    always_comb begin
        amount   = is_store ? CNT_W'(delta) : CNT_W'(1);
        sum      = {1'b0, old_val} + {1'b0, amount};
        up_val   = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        down_val = (old_val > amount) ? (old_val - amount) : '0;
        upd_en   = 1'b0;
        new_val  = old_val;
        unique case (opc)
            OPC_INC: begin
                upd_en  = 1'b1;
                new_val = is_group ? up_val : CNT_W'(1);
            end
            OPC_DEC: begin
                upd_en  = 1'b1;
                new_val = is_group ? down_val : '0;
            end
            default: begin
                upd_en  = 1'b0;
                new_val = old_val;
            end
        endcase
    end

    always_comb begin
        if (opc == OPC_DEC) begin
            a_r5_no_underflow: assert (new_val <= old_val)
                else $error("decrement raised a counter");
        end
        if (opc == OPC_INC && is_group) begin
            a_r4_inc_monotone: assert (new_val >= old_val)
                else $error("group increment wrapped");
        end
    end
endmodule

// File: rtl/bklg_counter_array.sv
module bklg_counter_array
    import bklg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_TARGETS = 3,
    parameter int CNT_W       = 16,
    parameter int DELTA_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DELTA_W-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [CNT_W-1:0]   rsp_rdata
);
    localparam int TGT_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;

    typedef struct packed {
        logic [NUM_TARGETS-1:0][NUM_PRIO-1:0]            proc;
        logic [NUM_TARGETS-1:0][NUM_PRIO-1:0][CNT_W-1:0] grp;
        logic                                            rsp_valid;
        logic [CNT_W-1:0]                                rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic              dec_mapped;
    logic [TGT_W-1:0]  dec_tgt;
    logic              dec_grp;
    logic [PRIO_W-1:0] dec_prio;
    bklg_opc_e         dec_opc;
    logic [CNT_W-1:0]  cur_val;
    logic [CNT_W-1:0]  nxt_val;
    logic              nxt_en;

    bklg_decode #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_TARGETS(NUM_TARGETS)
    ) u_decode (
        .addr(req_addr), .mapped(dec_mapped), .tgt(dec_tgt),
        .is_group(dec_grp), .prio(dec_prio), .opc(dec_opc)
    );

    always_comb begin
        cur_val = '0;
        if (dec_mapped) begin
            cur_val = dec_grp ? st_q.grp[dec_tgt][dec_prio]
                              : CNT_W'(st_q.proc[dec_tgt][dec_prio]);
        end
    end

    bklg_step #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_step (
        .old_val(cur_val), .is_group(dec_grp), .is_store(req_write),
        .opc(dec_opc), .delta(req_wdata), .new_val(nxt_val), .upd_en(nxt_en)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rsp_data  = (req_valid && !req_write) ? cur_val : '0;
        if (req_valid && dec_mapped && nxt_en) begin
            if (dec_grp) st_d.grp[dec_tgt][dec_prio]  = nxt_val;
            else         st_d.proc[dec_tgt][dec_prio] = nxt_val[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_data;

    a_r2_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid);
    a_r2_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> !rsp_valid);
    a_r3_proc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && dec_mapped && !dec_grp |=> rsp_rdata <= CNT_W'(1));
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !dec_mapped |=> rsp_rdata == '0);
    a_r7_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dec_mapped && dec_grp && dec_opc[1]
        |=> st_q.grp[$past(dec_tgt)][$past(dec_prio)] == $past(cur_val));
endmodule

// File: tb/bklg_counter_array_bench.sv
module bklg_counter_array_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bklg_counter_array u_bklg_counter_array (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  idx;
        logic        grp;
        logic [1:0]  opc;
        logic [2:0]  prio;
        logic [7:0]  delta;
        logic [15:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 1'b0, 2'b10, 3'd0, 8'd0,   16'd0,   4'd8}, // R8 reset zero
        '{1'b1, 3'd1, 1'b0, 2'b00, 3'd2, 8'd7,   16'd0,   4'd3},
        '{1'b0, 3'd1, 1'b0, 2'b00, 3'd2, 8'd0,   16'd1,   4'd6}, // R6 inc load, prior 1
        '{1'b0, 3'd1, 1'b0, 2'b11, 3'd2, 8'd0,   16'd1,   4'd3}, // R3 clamp held at 1
        '{1'b0, 3'd1, 1'b0, 2'b01, 3'd2, 8'd0,   16'd1,   4'd6}, // R6 dec load
        '{1'b0, 3'd1, 1'b0, 2'b10, 3'd2, 8'd0,   16'd0,   4'd6},
        '{1'b1, 3'd1, 1'b0, 2'b00, 3'd2, 8'd3,   16'd0,   4'd3},
        '{1'b0, 3'd1, 1'b0, 2'b10, 3'd2, 8'd0,   16'd1,   4'd3}, // R3
        '{1'b1, 3'd1, 1'b0, 2'b01, 3'd2, 8'd5,   16'd0,   4'd3},
        '{1'b0, 3'd1, 1'b0, 2'b10, 3'd2, 8'd0,   16'd0,   4'd3}, // R3
        '{1'b1, 3'd1, 1'b1, 2'b01, 3'd2, 8'd9,   16'd0,   4'd5},
        '{1'b0, 3'd1, 1'b1, 2'b11, 3'd2, 8'd0,   16'd0,   4'd5}, // R5 floor at zero
        '{1'b1, 3'd1, 1'b1, 2'b00, 3'd2, 8'd9,   16'd0,   4'd4},
        '{1'b0, 3'd1, 1'b1, 2'b00, 3'd2, 8'd0,   16'd9,   4'd6}, // R6 then 10
        '{1'b0, 3'd1, 1'b1, 2'b01, 3'd2, 8'd0,   16'd10,  4'd6}, // R6 then 9
        '{1'b0, 3'd1, 1'b1, 2'b10, 3'd2, 8'd0,   16'd9,   4'd6},
        '{1'b1, 3'd1, 1'b1, 2'b10, 3'd2, 8'd50,  16'd0,   4'd7},
        '{1'b0, 3'd1, 1'b1, 2'b11, 3'd2, 8'd0,   16'd9,   4'd7}, // R7 peek store ignored
        '{1'b0, 3'd1, 1'b1, 2'b10, 3'd3, 8'd0,   16'd0,   4'd9}, // R9 other priority
        '{1'b0, 3'd2, 1'b1, 2'b10, 3'd2, 8'd0,   16'd0,   4'd1}, // R1 other target
        '{1'b1, 3'd1, 1'b1, 2'b00, 3'd7, 8'd200, 16'd0,   4'd4},
        '{1'b1, 3'd1, 1'b1, 2'b00, 3'd7, 8'd55,  16'd0,   4'd4},
        '{1'b0, 3'd1, 1'b1, 2'b10, 3'd7, 8'd0,   16'd255, 4'd4}, // R4
        '{1'b1, 3'd1, 1'b1, 2'b01, 3'd7, 8'd100, 16'd0,   4'd5},
        '{1'b0, 3'd1, 1'b1, 2'b10, 3'd7, 8'd0,   16'd155, 4'd5}, // R5
        '{1'b0, 3'd2, 1'b0, 2'b01, 3'd0, 8'd0,   16'd0,   4'd5}  // R5 dec load on zero
    };

    function automatic logic [15:0] mk_addr(input logic [2:0] idx, input logic grp,
                                            input logic [1:0] opc, input logic [2:0] prio);
        return {idx, grp, opc, 3'b000, prio, 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] addr, input logic [7:0] d,
                          output logic v, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        v = rsp_valid; rd = rsp_rdata;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic        v;
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        check("R8 reset rsp_valid low", {15'd0, rsp_valid}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, mk_addr(VECS[i].idx, VECS[i].grp, VECS[i].opc, VECS[i].prio),
                   VECS[i].delta, v, rd);
            if (VECS[i].wr) begin
                check($sformatf("R2 store no response (vec %0d)", i), {15'd0, v}, 16'd0);
            end else begin
                check($sformatf("R2 load response (vec %0d)", i), {15'd0, v}, 16'd1);
                check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].expv);
            end
        end
        access(1'b0, mk_addr(3'd2, 1'b0, 2'b10, 3'd0), 8'd0, v, rd);
        check("R5 processor dec load stays zero", rd, 16'd0);

        // R4 saturation: 258 * 255 exceeds 0xFFFF
        for (int k = 0; k < 258; k++) access(1'b1, mk_addr(3'd0, 1'b1, 2'b00, 3'd5), 8'd255, v, rd);
        access(1'b0, mk_addr(3'd0, 1'b1, 2'b00, 3'd5), 8'd0, v, rd);
        check("R4 saturated inc load prior", rd, 16'hFFFF);
        access(1'b0, mk_addr(3'd0, 1'b1, 2'b10, 3'd5), 8'd0, v, rd);
        check("R4 stays at ceiling", rd, 16'hFFFF);
        access(1'b0, mk_addr(3'd0, 1'b0, 2'b10, 3'd5), 8'd0, v, rd);
        check("R9 processor counter untouched by group", rd, 16'd0);

        // R8 unmapped index
        access(1'b1, mk_addr(3'd3, 1'b1, 2'b00, 3'd0), 8'd5, v, rd);
        access(1'b0, mk_addr(3'd3, 1'b1, 2'b10, 3'd0), 8'd0, v, rd);
        check("R8 unmapped index reads zero", rd, 16'd0);
        check("R8 unmapped load still answers", {15'd0, v}, 16'd1);
        access(1'b0, mk_addr(3'd0, 1'b1, 2'b10, 3'd0), 8'd0, v, rd);
        check("R8 unmapped store did not alias", rd, 16'd0);
        // R8 stray offset bits
        access(1'b0, mk_addr(3'd1, 1'b1, 2'b10, 3'd2) | 16'h0001, 8'd0, v, rd);
        check("R8 stray bit reads zero", rd, 16'd0);
        access(1'b1, mk_addr(3'd1, 1'b1, 2'b00, 3'd2) | 16'h0080, 8'd40, v, rd);
        access(1'b0, mk_addr(3'd1, 1'b1, 2'b10, 3'd2), 8'd0, v, rd);
        check("R8 stray store ignored", rd, 16'd9);

        // R8 reset clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, mk_addr(3'd1, 1'b1, 2'b10, 3'd2), 8'd0, v, rd);
        check("R8 reset clears group", rd, 16'd0);
        access(1'b0, mk_addr(3'd0, 1'b1, 2'b10, 3'd5), 8'd0, v, rd);
        check("R8 reset clears saturated", rd, 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule